// File: doc/BRIEF.md
# Timed Car Wash Sequencer

This block steps one car through a fixed wash programme. It waits in `PH_IDLE` until the car-present input is seen. It then runs five operating phases in a fixed order: `PH_RINSE1` (sprinkler), `PH_SOAP` (soap), `PH_SCRUB` (scrubber), `PH_RINSE2` (sprinkler) and `PH_DRY` (dryer). After the dry phase it returns to `PH_IDLE` and raises an exit light.

Each phase has its own length, set by a parameter and counted in clock cycles. An internal down-counting timer is reloaded with the length of the phase being entered. It gives a one-cycle done pulse when it reaches zero, and it then rests at zero until the next reload. Once a wash has started, that done pulse is the only thing that moves the machine on.

The named transitions are as follows:
- **start**: `PH_IDLE`→`PH_RINSE1` when the car input is high.
- **to_soap**: `PH_RINSE1`→`PH_SOAP` on timer done.
- **to_scrub**: `PH_SOAP`→`PH_SCRUB` on timer done.
- **to_rinse2**: `PH_SCRUB`→`PH_RINSE2` on timer done.
- **to_dry**: `PH_RINSE2`→`PH_DRY` on timer done.
- **finish**: `PH_DRY`→`PH_IDLE` on timer done. This transition also arms the exit light.

Any other code falls back to `PH_IDLE`.

Top module: `carwash_seq`

## Requirements
- R1: While the synchronous reset is high, at each rising edge the phase code becomes 0 (`PH_IDLE`), and all four actuators and the exit light go low.
- R2: If the car input is high in `PH_IDLE` at a rising edge, the phase code in the next cycle is 1 (`PH_RINSE1`) and the sprinkler is on.
- R3: The phase codes follow the order 1 (first wash), 2 (soap), 3 (scrub), 4 (second wash), 5 (dry), then 0 (idle). Codes 6 and 7 never appear.
- R4: Each operating phase holds its code for exactly its duration parameter in clock cycles. Each duration must be at least 2. The internal timer done signal is never high on two cycles in a row.
- R5: The actuator outputs are registered and line up with the phase code. The sprinkler is on in codes 1 and 4, soap in code 2, the scrubber in code 3 and the dryer in code 5. Exactly one actuator is on in each operating phase, and none is on in idle.
- R6: The car input has no effect while the phase code is not 0. The phase code and the phase timing are the same as with the input held low.
- R7: The exit light goes high in the first idle cycle after the dry phase. It stays high for exactly `EXIT_HOLD` cycles if no car arrives.
- R8: A car accepted while the exit light is on ends it. The exit light is low in the same cycle that the phase code becomes 1, and it is low in every operating phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| car_in | input | 1 | Car-present input |
| spray_o | output | 1 | Sprinkler drive |
| soap_o | output | 1 | Soap drive |
| scrub_o | output | 1 | Scrubber drive |
| dryer_o | output | 1 | Dryer drive |
| exit_o | output | 1 | Exit light |
| phase_o | output | 3 | Current phase code (0 idle, 1 first wash to 5 dry) |

## Verification
The phase code and the actuators change one clock edge after the input or timer event that causes them. A car sampled at edge N shows as code 1 in the cycle after N. A phase entered at edge E is left at edge E+D. The exit light rises at the same edge as the return to idle, and it falls either `EXIT_HOLD` edges later or at the edge that accepts the next car.

The bench drives `car_in` on the falling edge. It advances its own model by exactly one step per rising edge and compares every output 1 ns after that edge, so each result is checked in the cycle it is due. Phase lengths are also measured directly from the observed code, so they do not depend on the model.

// File: rtl/wash_pkg.sv
`timescale 1ns/1ps
package wash_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_RINSE1 = 3'd1,
        PH_SOAP   = 3'd2,
        PH_SCRUB  = 3'd3,
        PH_RINSE2 = 3'd4,
        PH_DRY    = 3'd5
    } phase_e;

    typedef struct packed {
        logic spray;
        logic soap;
        logic scrub;
        logic dryer;
    } act_s;

    // Actuator pattern that belongs to a phase.
    function automatic act_s act_for(phase_e ph);
        act_s a;
        a = '0;
        case (ph)
            PH_RINSE1, PH_RINSE2: a.spray = 1'b1;
            PH_SOAP:              a.soap  = 1'b1;
            PH_SCRUB:             a.scrub = 1'b1;
            PH_DRY:               a.dryer = 1'b1;
            default:              a = '0;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/wash_timer.sv
`timescale 1ns/1ps
module wash_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    // Down-counter: a reload wins, otherwise count down and rest at zero.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            done  <= 1'b0;
        end else begin
            done <= !load && (cnt_q == ONE);
            if (load) begin
                cnt_q <= load_val;
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - ONE;
            end
        end
    end

endmodule

// File: rtl/wash_fsm.sv
`timescale 1ns/1ps
module wash_fsm
    import wash_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int D_RINSE1 = 6,
    parameter int D_SOAP   = 4,
    parameter int D_SCRUB  = 5,
    parameter int D_RINSE2 = 3,
    parameter int D_DRY    = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             car_in,
    input  logic             tmr_done,
    output phase_e           state_q,
    output phase_e           state_d,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val
);

    // The timer is loaded with length-1 so that done lands on the last cycle.
    localparam logic [CNT_W-1:0] LD_RINSE1 = CNT_W'(D_RINSE1 - 1);
    localparam logic [CNT_W-1:0] LD_SOAP   = CNT_W'(D_SOAP - 1);
    localparam logic [CNT_W-1:0] LD_SCRUB  = CNT_W'(D_SCRUB - 1);
    localparam logic [CNT_W-1:0] LD_RINSE2 = CNT_W'(D_RINSE2 - 1);
    localparam logic [CNT_W-1:0] LD_DRY    = CNT_W'(D_DRY - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDLE:   if (car_in)   state_d = PH_RINSE1;   // start
            PH_RINSE1: if (tmr_done) state_d = PH_SOAP;     // to_soap
            PH_SOAP:   if (tmr_done) state_d = PH_SCRUB;    // to_scrub
            PH_SCRUB:  if (tmr_done) state_d = PH_RINSE2;   // to_rinse2
            PH_RINSE2: if (tmr_done) state_d = PH_DRY;      // to_dry
            PH_DRY:    if (tmr_done) state_d = PH_IDLE;     // finish
            default:                 state_d = PH_IDLE;
        endcase
    end

    // Reload on every entry into an operating phase.
    always_comb begin
        tmr_load = (state_d != state_q) && (state_d != PH_IDLE);
        unique case (state_d)
            PH_RINSE1: tmr_val = LD_RINSE1;
            PH_SOAP:   tmr_val = LD_SOAP;
            PH_SCRUB:  tmr_val = LD_SCRUB;
            PH_RINSE2: tmr_val = LD_RINSE2;
            PH_DRY:    tmr_val = LD_DRY;
            default:   tmr_val = '0;
        endcase
    end

endmodule

// File: rtl/wash_outputs.sv
`timescale 1ns/1ps
module wash_outputs
    import wash_pkg::*;
#(
    parameter int EXIT_HOLD = 3
) (
    input  logic   clk,
    input  logic   rst,
    input  phase_e state_q,
    input  phase_e state_d,
    output act_s   act_q,
    output logic   exit_o
);

    localparam int EXIT_W = $clog2(EXIT_HOLD + 1);
    localparam logic [EXIT_W-1:0] HOLD_LD = EXIT_W'(EXIT_HOLD);
    localparam logic [EXIT_W-1:0] ONE     = EXIT_W'(1);

    logic              starting;
    logic              finishing;
    logic [EXIT_W-1:0] exit_q;

    assign starting  = (state_q == PH_IDLE) && (state_d != PH_IDLE);
    assign finishing = (state_q == PH_DRY)  && (state_d == PH_IDLE);

    // Actuators are registered from the next state so they track state_q.
    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= '0;
        end else begin
            act_q <= act_for(state_d);
        end
    end

    // Exit light hold counter.
    always_ff @(posedge clk) begin
        if (rst) begin
            exit_q <= '0;
        end else if (finishing) begin
            exit_q <= HOLD_LD;
        end else if (starting) begin
            exit_q <= '0;
        end else if (exit_q != '0) begin
            exit_q <= exit_q - ONE;
        end
    end

    assign exit_o = (exit_q != '0);

endmodule

// File: rtl/carwash_seq.sv
`timescale 1ns/1ps
module carwash_seq
    import wash_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int D_RINSE1  = 6,
    parameter int D_SOAP    = 4,
    parameter int D_SCRUB   = 5,
    parameter int D_RINSE2  = 3,
    parameter int D_DRY     = 7,
    parameter int EXIT_HOLD = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       car_in,
    output logic       spray_o,
    output logic       soap_o,
    output logic       scrub_o,
    output logic       dryer_o,
    output logic       exit_o,
    output logic [2:0] phase_o
);

    phase_e           state_q;
    phase_e           state_d;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;
    act_s             act_q;

    wash_fsm #(
        .CNT_W   (CNT_W),
        .D_RINSE1(D_RINSE1),
        .D_SOAP  (D_SOAP),
        .D_SCRUB (D_SCRUB),
        .D_RINSE2(D_RINSE2),
        .D_DRY   (D_DRY)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .car_in  (car_in),
        .tmr_done(tmr_done),
        .state_q (state_q),
        .state_d (state_d),
        .tmr_load(tmr_load),
        .tmr_val (tmr_val)
    );

    wash_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .load_val(tmr_val),
        .done    (tmr_done)
    );

    wash_outputs #(
        .EXIT_HOLD(EXIT_HOLD)
    ) u_out (
        .clk    (clk),
        .rst    (rst),
        .state_q(state_q),
        .state_d(state_d),
        .act_q  (act_q),
        .exit_o (exit_o)
    );

    assign spray_o = act_q.spray;
    assign soap_o  = act_q.soap;
    assign scrub_o = act_q.scrub;
    assign dryer_o = act_q.dryer;
    assign phase_o = state_q;

endmodule

// File: rtl/wash_chk.sv
`timescale 1ns/1ps
module wash_chk (
    input logic       clk,
    input logic       rst,
    input logic       car_in,
    input logic       tmr_done,
    input logic [2:0] phase,
    input logic       spray,
    input logic       soap,
    input logic       scrub,
    input logic       dryer,
    input logic       exit_ind
);

    p_start_r2: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd0) && car_in |=> (phase == 3'd1) && spray);

    p_code_legal_r3: assert property (@(posedge clk) disable iff (rst)
        phase <= 3'd5);

    p_order_r3: assert property (@(posedge clk) disable iff (rst)
        (phase != $past(phase)) && ($past(phase) != 3'd0)
        |-> phase == (($past(phase) == 3'd5) ? 3'd0 : $past(phase) + 3'd1));

    p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        tmr_done |=> !tmr_done);

    p_one_act_r5: assert property (@(posedge clk) disable iff (rst)
        (phase != 3'd0) |-> $countones({spray, soap, scrub, dryer}) == 1);

    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd0) |-> {spray, soap, scrub, dryer} == 4'b0000);

    p_ignore_car_r6: assert property (@(posedge clk) disable iff (rst)
        (phase != 3'd0) && car_in && !tmr_done |=> phase == $past(phase));

    p_exit_on_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(phase) == 3'd5) && (phase == 3'd0) |-> exit_ind);

    p_exit_off_r8: assert property (@(posedge clk) disable iff (rst)
        (phase != 3'd0) |-> !exit_ind);

endmodule

bind carwash_seq wash_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .car_in  (car_in),
    .tmr_done(tmr_done),
    .phase   (phase_o),
    .spray   (spray_o),
    .soap    (soap_o),
    .scrub   (scrub_o),
    .dryer   (dryer_o),
    .exit_ind(exit_o)
);

// File: tb/sim_carwash_seq.sv
`timescale 1ns/1ps
module sim_carwash_seq;

    localparam int D1 = 6;
    localparam int D2 = 4;
    localparam int D3 = 5;
    localparam int D4 = 3;
    localparam int D5 = 7;
    localparam int HOLD = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       car_in = 1'b0;
    logic       spray_o, soap_o, scrub_o, dryer_o, exit_o;
    logic [2:0] phase_o;

    int checks = 0;
    int fails  = 0;

    // Bench model state
    int m_ph   = 0;
    int m_left = 0;
    int m_exit = 0;
    // Measured phase lengths
    int run_ph  = 0;
    int run_len = 0;

    always #2 clk = ~clk;

    carwash_seq #(
        .D_RINSE1(D1), .D_SOAP(D2), .D_SCRUB(D3),
        .D_RINSE2(D4), .D_DRY(D5), .EXIT_HOLD(HOLD)
    ) u0 (
        .clk(clk), .rst(rst), .car_in(car_in),
        .spray_o(spray_o), .soap_o(soap_o), .scrub_o(scrub_o),
        .dryer_o(dryer_o), .exit_o(exit_o), .phase_o(phase_o)
    );

    function automatic int dur_of(input int ph);
        case (ph)
            1: return D1;
            2: return D2;
            3: return D3;
            4: return D4;
            5: return D5;
            default: return 0;
        endcase
    endfunction

    // {spray, soap, scrub, dryer}
    function automatic int act_of(input int ph);
        case (ph)
            1, 4: return 8;
            2:    return 4;
            3:    return 2;
            5:    return 1;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, advance the model at the rising edge, compare 1 ns later.
    task automatic step(input bit car);
        int    prev_ph, prev_exit, act;
        string lab;
        @(negedge clk);
        car_in = car;
        prev_ph = m_ph;
        prev_exit = m_exit;
        @(posedge clk);
        if (m_ph == 0) begin
            if (car) begin
                m_ph = 1; m_left = dur_of(1); m_exit = 0;
            end else if (m_exit > 0) begin
                m_exit--;
            end
        end else begin
            m_left--;
            if (m_left == 0) begin
                if (m_ph == 5) begin
                    m_ph = 0; m_exit = HOLD;
                end else begin
                    m_ph++; m_left = dur_of(m_ph);
                end
            end
        end
        #1;
        if (car && prev_ph == 0) lab = (prev_exit > 0) ? "R8" : "R2";
        else if (car)            lab = "R6";
        else                     lab = "R3";
        chk(phase_o == 3'(m_ph), lab, "phase", int'(phase_o), m_ph);
        act = int'({spray_o, soap_o, scrub_o, dryer_o});
        chk(act == act_of(m_ph), "R5", "actuators", act, act_of(m_ph));
        chk(exit_o == (m_exit > 0), (lab == "R8") ? "R8" : "R7", "exit",
            int'(exit_o), int'(m_exit > 0));
        // Direct length measurement
        if (int'(phase_o) == run_ph) begin
            run_len++;
        end else begin
            if (run_ph != 0)
                chk(run_len == dur_of(run_ph), "R4", "phase length", run_len, dur_of(run_ph));
            run_ph = int'(phase_o);
            run_len = 1;
        end
    endtask

    task automatic drain();
        for (int i = 0; i < 200 && (m_ph != 0 || m_exit != 0); i++) step(1'b0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        chk(phase_o == 3'd0, "R1", "phase after reset", int'(phase_o), 0);
        chk({spray_o, soap_o, scrub_o, dryer_o} == 4'b0, "R1", "actuators after reset",
            int'({spray_o, soap_o, scrub_o, dryer_o}), 0);
        chk(exit_o == 1'b0, "R1", "exit after reset", int'(exit_o), 0);
        @(negedge clk);
        rst = 1'b0;

        // Idle without a car stays idle
        repeat (4) step(1'b0);
        // Single pulse start, full programme, full exit hold
        step(1'b1);
        drain();
        // Car held high throughout: ignored mid-wash, restart in exit hold, back-to-back washes
        step(1'b1);
        for (int i = 0; i < 200 && m_ph != 0; i++) step(1'b1);
        step(1'b1);
        for (int i = 0; i < 200 && m_ph != 0; i++) step(1'b1);
        step(1'b0);
        step(1'b1);
        drain();
        // Random car traffic
        for (int i = 0; i < 4000; i++) step(($urandom % 16) == 0);
        drain();

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule